// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits inside a per-processor interrupt controller. Software sets it up through three writable registers on a small write port. The first register sets the start value of the countdown, the second sets the clock prescaler, and the third is the timer's vector entry, which holds the interrupt vector, a mask flag and a mode flag. Writing a start value restarts the count. From then on the counter moves down by one on every prescaled tick. The current value is always visible on an output.

In one-shot mode the timer raises one request once the count is spent. In periodic mode the counter reloads and raises a request on every wrap. A request is a single-cycle pulse that carries the vector from the entry. The logic that delivers the interrupt after the pulse is outside this block.

Top module: `lict_timer`

## Requirements
- R1: After reset the current count is 0, no pulse is raised, the vector entry is masked (entry value 0x10000), the divide code is 0 and the start value is 0.
- R2: A write with `wr_sel`=1 sets the divide code. The code is built from `wr_data[3]` as its top bit and `wr_data[1:0]` below it, and `wr_data[2]` is ignored. The prescaled tick period is 2^((code+1) mod 8) clock cycles, so code 3'b111 ticks every cycle, code 3'b000 ticks every 2 cycles and code 3'b011 ticks every 16 cycles.
- R3: A write with `wr_sel`=0 loads `wr_data` as the start value. The current count equals that value in the next cycle, and the prescaler restarts, so tick n falls on clock edge n·2^shift after the write edge.
- R4: In one-shot mode (entry bit 17 = 0) the count after tick T is max(start−T, 0). One pulse is raised, on tick start+1, and none after it.
- R5: In periodic mode (entry bit 17 = 1) the count after tick T is start − (T mod (start+1)). A pulse is raised on every tick T>0 with T mod (start+1) = 0.
- R6: A start value of 0 never raises a pulse, in either mode.
- R7: While the mask flag (entry bit 16) is set, no pulse is raised but counting continues. An entry write takes effect from the next clock edge, so clearing the mask in the middle of a run lets the next wrap fire.
- R8: A pulse lasts one cycle and carries entry bits [7:0] on `irq_vector`. The vector output is 0 when there is no pulse.
- R9: No pulse is raised in the cycle that follows a start-value write, even if the old schedule would have expired on that edge.
- R10: A write with `wr_sel`=3 changes nothing: count, schedule, vector and mask stay as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start value, 1 divide, 2 vector entry, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the pulse, 0 otherwise |

## Verification
A wrong count register shows up on `cur_count` on the very next prescaled tick, because the bench compares the count every cycle against the closed-form value for the ticks elapsed since the last start write. A lost armed state, a reload that comes one tick early, or a prescaler that has drifted shows up as a pulse in the wrong cycle or a missing pulse, at the first expiry at the latest (start+1 ticks). A mask or vector field that was stored wrongly appears at the first pulse that the bench expects or forbids. A stray write decode shows up as a changed vector or a restarted count.

// File: rtl/lict_pkg.sv
package lict_pkg;
   typedef enum logic [1:0] {
      SEL_INIT  = 2'd0,
      SEL_DIV   = 2'd1,
      SEL_ENTRY = 2'd2,
      SEL_NONE  = 2'd3
   } lict_sel_e;

   localparam int          ENTRY_PERIODIC_BIT = 17;
   localparam int          ENTRY_MASK_BIT     = 16;
   localparam logic [31:0] ENTRY_RESET        = 32'h0001_0000;

   // split divide code {bit3, bit1, bit0}; shift = (code + 1) mod 8
   function automatic logic [2:0] div_to_shift(input logic [3:0] d);
      return {d[3], d[1:0]} + 3'd1;
   endfunction
endpackage

// File: rtl/lict_cfg.sv
module lict_cfg
   import lict_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int VEC_W   = 8,
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               restart_o,
   output logic [CNT_W-1:0]   init_o,
   output logic [SHIFT_W-1:0] shift_o,
   output logic               periodic_o,
   output logic               masked_o,
   output logic [VEC_W-1:0]   vec_o
);
   localparam logic [3:0] DIV_RESET = 4'h0;

   generate
      if (SHIFT_W != 3) begin : g_bad_shift
         $error("lict_cfg: divide decode yields exactly 3 shift bits");
      end
      if (DATA_W <= ENTRY_PERIODIC_BIT || CNT_W > DATA_W || VEC_W > ENTRY_MASK_BIT) begin : g_bad_width
         $error("lict_cfg: field widths do not fit the write data");
      end
   endgenerate

   lict_sel_e sel;
   assign sel       = lict_sel_e'(wr_sel);
   assign restart_o = wr_en && (sel == SEL_INIT);
   assign init_o    = wr_data[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_o    <= div_to_shift(DIV_RESET);
         periodic_o <= ENTRY_RESET[ENTRY_PERIODIC_BIT];
         masked_o   <= ENTRY_RESET[ENTRY_MASK_BIT];
         vec_o      <= ENTRY_RESET[VEC_W-1:0];
      end else if (wr_en) begin
         if (sel == SEL_DIV) begin
            shift_o <= div_to_shift(wr_data[3:0]);
         end
         if (sel == SEL_ENTRY) begin
            periodic_o <= wr_data[ENTRY_PERIODIC_BIT];
            masked_o   <= wr_data[ENTRY_MASK_BIT];
            vec_o      <= wr_data[VEC_W-1:0];
         end
      end
   end

   // R10
   sel_none_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_NONE) |=> (shift_o == $past(shift_o)) && (vec_o == $past(vec_o))
                                   && (masked_o == $past(masked_o)) && (periodic_o == $past(periodic_o)));
endmodule

// File: rtl/lict_prescaler.sv
module lict_prescaler #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic               tick_o
);
   localparam int PW = (1 << SHIFT_W) - 1;

   generate
      if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_param
         $error("lict_prescaler: SHIFT_W out of range");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] low_mask;

   generate
      for (genvar i = 0; i < PW; i++) begin : g_mask
         assign low_mask[i] = (shift_i > SHIFT_W'(i));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) cnt_q <= '0;
      else                     cnt_q <= cnt_q + PW'(1);
   end

   assign tick_o = &(cnt_q | ~low_mask);

   // R3
   restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && shift_i != '0) |=> !tick_o);
endmodule

// File: rtl/lict_downcounter.sv
module lict_downcounter #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] init_i,
   input  logic             tick_i,
   input  logic             periodic_i,
   input  logic             masked_i,
   input  logic [VEC_W-1:0] vec_i,
   output logic [CNT_W-1:0] cur_o,
   output logic             irq_o,
   output logic [VEC_W-1:0] irq_vec_o
);
   generate
      if (CNT_W < 2 || VEC_W < 1) begin : g_bad_param
         $error("lict_downcounter: bad width");
      end
   endgenerate

   logic [CNT_W-1:0] cur_q, cur_d, init_q, init_d;
   logic             armed_q, armed_d, fire;

   always_comb begin
      cur_d   = cur_q;
      init_d  = init_q;
      armed_d = armed_q;
      fire    = 1'b0;
      if (restart_i) begin
         cur_d   = init_i;
         init_d  = init_i;
         armed_d = (init_i != '0);
      end else if (tick_i) begin
         if (cur_q != '0) begin
            cur_d = cur_q - CNT_W'(1);
         end else if (periodic_i) begin
            cur_d   = init_q;
            fire    = (init_q != '0);
            armed_d = 1'b0;
         end else if (armed_q) begin
            fire    = 1'b1;
            armed_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         init_q    <= '0;
         armed_q   <= 1'b0;
         irq_o     <= 1'b0;
         irq_vec_o <= '0;
      end else begin
         cur_q     <= cur_d;
         init_q    <= init_d;
         armed_q   <= armed_d;
         irq_o     <= fire && !masked_i;
         irq_vec_o <= (fire && !masked_i) ? vec_i : '0;
      end
   end

   assign cur_o = cur_q;

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R7
   mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(masked_i));
   // R4
   expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(cur_q) == '0) && $past(tick_i));
   // R6
   zero_start_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(init_q) != '0);
   // R9
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> !irq_o);
   // R5
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(restart_i) && cur_q != $past(cur_q)) |->
         (cur_q == $past(cur_q) - CNT_W'(1)) || ($past(cur_q) == '0));
endmodule

// File: rtl/lict_timer.sv
module lict_timer #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int VEC_W   = 8,
   parameter int SHIFT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cur_count,
   output logic              irq_pulse,
   output logic [VEC_W-1:0]  irq_vector
);
   logic               restart;
   logic [CNT_W-1:0]   init_val;
   logic [SHIFT_W-1:0] shift;
   logic               periodic, masked, tick;
   logic [VEC_W-1:0]   vec;

   lict_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .SHIFT_W(SHIFT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .restart_o(restart), .init_o(init_val), .shift_o(shift),
      .periodic_o(periodic), .masked_o(masked), .vec_o(vec)
   );

   lict_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .shift_i(shift), .tick_o(tick)
   );

   lict_downcounter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .init_i(init_val), .tick_i(tick),
      .periodic_i(periodic), .masked_i(masked), .vec_i(vec),
      .cur_o(cur_count), .irq_o(irq_pulse), .irq_vec_o(irq_vector)
   );
endmodule

// File: tb/lict_timer_tb.sv
`timescale 1ns/1ps
module lict_timer_tb;
   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] cur_count;
   logic        irq_pulse;
   logic [7:0]  irq_vector;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   lict_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
                     .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] s, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_cnt(int unsigned init, int s, bit per, int unsigned e);
      int unsigned t = e >> s;
      if (per) return init - (t % (init + 1));
      return (t >= init) ? 0 : init - t;
   endfunction

   function automatic bit exp_fire(int unsigned init, int s, bit per, bit msk, int unsigned e);
      int unsigned t = e >> s;
      if (msk || init == 0 || (e & ((1 << s) - 1)) != 0) return 0;
      if (per) return (t > 0) && (t % (init + 1) == 0);
      return t == init + 1;
   endfunction

   // checks edges e0+1 .. e1 after the start-value write
   task automatic follow(int unsigned init, int s, bit per, bit msk, logic [7:0] v,
                         int unsigned e0, int unsigned e1, string req);
      for (int unsigned e = e0 + 1; e <= e1; e++) begin
         @(negedge clk);
         check({req, " count"}, cur_count, exp_cnt(init, s, per, e));
         check({req, " pulse"}, {23'd0, irq_pulse, irq_vector},
               exp_fire(init, s, per, msk, e) ? {23'd0, 1'b1, v} : 32'd0);
      end
   endtask

   task automatic setup(logic [2:0] code, bit per, bit msk, logic [7:0] v, int unsigned init);
      wr(2'd1, {28'd0, code[2], 1'($urandom % 2), code[1:0]});
      wr(2'd2, {14'd0, per, msk, 8'd0, v});
      wr(2'd0, init);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1a7e));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count", cur_count, 0);
      check("R1 pulse", {31'd0, irq_pulse}, 0);
      // R1 masked entry, R2 default code 0 -> divide by 2: expiry at edge 6 is masked
      wr(2'd0, 2);
      follow(2, 1, 0, 1, 8'h00, 0, 9, "R1/R2 default");
      // R2 code 111 every cycle, code 011 every 16, bit 2 ignored
      setup(3'b111, 0, 0, 8'h21, 2);  follow(2, 0, 0, 0, 8'h21, 0, 6, "R2 div1 R4");
      setup(3'b011, 0, 0, 8'h22, 1);  follow(1, 4, 0, 0, 8'h22, 0, 40, "R2 div16 R4");
      setup(3'b000, 1, 0, 8'h23, 2);  follow(2, 1, 1, 0, 8'h23, 0, 20, "R2 div2 R5");
      // R6 zero start in both modes
      setup(3'b111, 1, 0, 8'h24, 0);  follow(0, 0, 1, 0, 8'h24, 0, 10, "R6 periodic");
      setup(3'b111, 0, 0, 8'h25, 0);  follow(0, 0, 0, 0, 8'h25, 0, 10, "R6 oneshot");
      // R7 unmask mid-run: periodic start 3 fires at 4,8,12
      setup(3'b111, 1, 1, 8'h26, 3);
      follow(3, 0, 1, 1, 8'h26, 0, 5, "R7 masked");
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = {14'd0, 1'b1, 1'b0, 8'd0, 8'h26};
      @(negedge clk); wr_en = 1'b0;
      check("R7 count", cur_count, exp_cnt(3, 0, 1, 6));
      follow(3, 0, 1, 0, 8'h26, 6, 12, "R7 unmasked");
      // R9 restart on the expiry edge: start 1 periodic would fire at 4
      setup(3'b111, 1, 0, 8'h5a, 1);
      follow(1, 0, 1, 0, 8'h5a, 0, 3, "R9 before");
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 7;
      @(negedge clk); wr_en = 1'b0;
      check("R9 pulse", {31'd0, irq_pulse}, 0);
      check("R3 reload", cur_count, 7);
      follow(7, 0, 1, 0, 8'h5a, 0, 10, "R3/R9 after");
      // R10 select 3 write mid-run
      setup(3'b111, 0, 0, 8'h33, 5);
      follow(5, 0, 0, 0, 8'h33, 0, 2, "R10 before");
      wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'd0;
      @(negedge clk); wr_en = 1'b0;
      check("R10 count", cur_count, exp_cnt(5, 0, 0, 3));
      follow(5, 0, 0, 0, 8'h33, 3, 9, "R10 after");
      // random runs, R4 R5 R8
      for (int r = 0; r < 24; r++) begin
         logic [2:0] code = 3'($urandom % 4) + 3'd7;
         int s = (int'(code) + 1) % 8;
         bit per = 1'($urandom % 2);
         bit msk = ($urandom % 5) == 0;
         logic [7:0] v = 8'($urandom);
         int unsigned init = $urandom % 13;
         setup(code, per, msk, v, init);
         follow(init, s, per, msk, v, 0, ((init + 1) << s) * 3 + 4, "R4/R5/R8 random");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule